// File: doc/BRIEF.md
# Packed Zero-Operand Stack Core

This block is a small execution core for a stack machine whose instructions carry no operand fields. Each 32-bit code word read from memory packs six 5-bit opcodes. The core runs them one after another, starting with the lowest slot. Operands come implicitly from the top one or two entries of a 16-entry data stack, and results are written back to the top. While the current word drains, a one-word prefetch buffer fills from the next stream address.

A literal opcode takes the next unread word of the instruction stream as data and pushes it. Several literal opcodes in one code word therefore take that many following stream words, in order, before the next code word is decoded. One memory port serves both instruction fetch and data access. Reads return their data on the cycle after the request. The jump opcodes reload the fetch address and flush everything that was already fetched.

Top module: `stk_core`

## Requirements
- R1: After reset, halted, stk_err, depth and tos read 0, and the first fetch request goes to word address 0.
- R2: Opcode slots are taken from bits [4:0] first, then [9:5], and so on up to [29:25]. Bits [31:30] of a code word have no effect.
- R3: Opcode 0 (NOP) ends the current code word. Its remaining slots are skipped, and the next unread stream word is decoded as code.
- R4: LIT (code 1) pushes the next unread stream word. N LITs in one code word consume the N words that follow it as literals, in slot order.
- R5: ADD (5), SUB (6, second minus top), AND (7) and XOR (8) pop two entries and push the result, so depth drops by one.
- R6: DUP (2) copies the top entry, DROP (3) removes it, and SWAP (4) exchanges the top two entries.
- R7: LOAD (9) replaces the top entry with the memory word at the address it held. STORE (10) writes the second entry to the address in the top entry and pops both.
- R8: JMP (11) pops a target word address and continues there. The remaining slots of the current word and any prefetched word are discarded.
- R9: JZ (12) pops the target (top) and the condition (second). It jumps when the condition is zero; otherwise execution continues with the next slot.
- R10: HALT (13) sets halted. From then on no memory request is issued, and depth and tos stay frozen.
- R11: An opcode that would push onto a full stack (16 entries), or that needs more entries than the stack holds, sets stk_err and halted and leaves the stack unchanged. The flag stays set until reset.
- R12: A write is signalled as mem_we together with mem_req, in the same cycle as the address and data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_req | output | 1 | Memory access request this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| halted | output | 1 | Core stopped by HALT or by a stack fault |
| stk_err | output | 1 | Sticky stack overflow or underflow flag |
| tos | output | 32 | Top stack entry, 0 when the stack is empty |
| depth | output | 5 | Number of stack entries |

## Verification
Short programs are loaded into a bench memory, and each one runs until the core halts. The programs mix literal counts per word, so literal order separates a correct SUB from an operand swap. A NOP followed by live DUPs shows whether a word ends early. The jump programs place DUPs after the jump and a HALT guard word in the fall-through path, so leftover slots or stale prefetched words change the final depth. A taken JZ and an untaken JZ give different final stacks. Fault programs check that overflow at 16 entries and underflow on SWAP leave the stack untouched. STORE followed by LOAD checks the memory round trip.

// File: rtl/stk_core_pkg.sv
package stk_core_pkg;

    localparam int OPW = 5;

    typedef enum logic [OPW-1:0] {
        OP_NOP   = 5'd0,
        OP_LIT   = 5'd1,
        OP_DUP   = 5'd2,
        OP_DROP  = 5'd3,
        OP_SWAP  = 5'd4,
        OP_ADD   = 5'd5,
        OP_SUB   = 5'd6,
        OP_AND   = 5'd7,
        OP_XOR   = 5'd8,
        OP_LOAD  = 5'd9,
        OP_STORE = 5'd10,
        OP_JMP   = 5'd11,
        OP_JZ    = 5'd12,
        OP_HALT  = 5'd13
    } op_e;

    typedef enum logic [1:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_XOR
    } alu_fn_e;

endpackage

// File: rtl/stk_core_alu.sv
module stk_core_alu
    import stk_core_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_fn_e        fn,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y
);

    // a is the second entry, b is the top entry
    always_comb begin
        case (fn)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            default: y = a ^ b;
        endcase
    end

endmodule

// File: rtl/stk_core_stack.sv
module stk_core_stack
    import stk_core_pkg::*;
#(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    pop_n,
    input  logic          push_en,
    input  logic [W-1:0]  push_val,
    input  logic          swap_en,
    output logic [W-1:0]  top,
    output logic [W-1:0]  nos,
    output logic [CW-1:0] cnt
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] ent;
        logic [CW-1:0]           cnt;
    } stk_t;

    stk_t          s_d, s_q;
    logic [CW-1:0] base;
    logic [IW-1:0] i_top, i_nos;

    assign i_top = IW'(s_q.cnt - CW'(1));
    assign i_nos = IW'(s_q.cnt - CW'(2));
    assign top   = s_q.ent[i_top];
    assign nos   = s_q.ent[i_nos];
    assign cnt   = s_q.cnt;

    always_comb begin
        s_d  = s_q;
        base = s_q.cnt - CW'(pop_n);
        if (swap_en) begin
            s_d.ent[i_top] = s_q.ent[i_nos];
            s_d.ent[i_nos] = s_q.ent[i_top];
        end else begin
            if (push_en) begin
                s_d.ent[IW'(base)] = push_val;
            end
            s_d.cnt = base + CW'(push_en);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/stk_core.sv
module stk_core
    import stk_core_pkg::*;
#(
    parameter int             W        = 32,
    parameter int             AW       = 16,
    parameter int             DEPTH    = 16,
    parameter logic [AW-1:0]  RESET_IP = '0,
    localparam int            CW       = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [W-1:0]  mem_wdata,
    input  logic [W-1:0]  mem_rdata,
    output logic          halted,
    output logic          stk_err,
    output logic [W-1:0]  tos,
    output logic [CW-1:0] depth
);

    localparam int SLOTS = W / OPW;
    localparam int SW    = $clog2(SLOTS + 1);

    typedef struct packed {
        logic [AW-1:0] ip;
        logic [W-1:0]  ir;
        logic [SW-1:0] slots;
        logic          ir_v;
        logic [W-1:0]  pb;
        logic          pb_v;
        logic          f_inflight;
        logic          load_wait;
        logic          halted;
        logic          err;
    } core_t;

    core_t         s_d, s_q;

    logic [1:0]    pop_n;
    logic          push_en;
    logic [W-1:0]  push_val;
    logic          swap_en;
    logic [W-1:0]  top, nos, alu_y;
    logic [CW-1:0] cnt;
    alu_fn_e       alu_fn;

    op_e           op;
    logic [1:0]    need;
    logic          grow;
    logic          under, over;
    logic          adv, jmp, dbusy;
    logic [AW-1:0] jtgt, faddr;

    stk_core_stack #(.W(W), .DEPTH(DEPTH)) stack_i (
        .clk      (clk),
        .rst      (rst),
        .pop_n    (pop_n),
        .push_en  (push_en),
        .push_val (push_val),
        .swap_en  (swap_en),
        .top      (top),
        .nos      (nos),
        .cnt      (cnt)
    );

    stk_core_alu #(.W(W)) alu_i (
        .fn (alu_fn),
        .a  (nos),
        .b  (top),
        .y  (alu_y)
    );

    always_comb begin
        s_d       = s_q;
        pop_n     = '0;
        push_en   = 1'b0;
        push_val  = '0;
        swap_en   = 1'b0;
        alu_fn    = ALU_ADD;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        adv       = 1'b0;
        jmp       = 1'b0;
        dbusy     = 1'b0;
        jtgt      = top[AW-1:0];
        faddr     = s_q.ip;
        op        = op_e'(s_q.ir[OPW-1:0]);

        // stack demand of the current opcode
        case (op)
            OP_LIT:                         begin need = 2'd0; grow = 1'b1; end
            OP_DUP:                         begin need = 2'd1; grow = 1'b1; end
            OP_DROP, OP_LOAD, OP_JMP:       begin need = 2'd1; grow = 1'b0; end
            OP_SWAP, OP_ADD, OP_SUB,
            OP_AND, OP_XOR, OP_STORE, OP_JZ: begin need = 2'd2; grow = 1'b0; end
            default:                        begin need = 2'd0; grow = 1'b0; end
        endcase
        under = cnt < CW'(need);
        over  = grow && (cnt == CW'(DEPTH));

        case (op)
            OP_SUB:  alu_fn = ALU_SUB;
            OP_AND:  alu_fn = ALU_AND;
            OP_XOR:  alu_fn = ALU_XOR;
            default: alu_fn = ALU_ADD;
        endcase

        // instruction fetch response lands in the prefetch buffer
        if (s_q.f_inflight) begin
            s_d.f_inflight = 1'b0;
            s_d.pb         = mem_rdata;
            s_d.pb_v       = 1'b1;
        end

        if (!s_q.halted) begin
            if (s_q.load_wait) begin
                pop_n         = 2'd1;
                push_en       = 1'b1;
                push_val      = mem_rdata;
                s_d.load_wait = 1'b0;
                adv           = 1'b1;
            end else if (!s_q.ir_v) begin
                if (s_q.pb_v) begin
                    s_d.ir    = s_q.pb;
                    s_d.slots = SW'(SLOTS);
                    s_d.ir_v  = 1'b1;
                    s_d.pb_v  = 1'b0;
                end
            end else if (op == OP_NOP) begin
                s_d.ir_v = 1'b0;
            end else if (under || over) begin
                s_d.halted = 1'b1;
                s_d.err    = 1'b1;
            end else begin
                case (op)
                    OP_LIT: begin
                        if (s_q.pb_v) begin
                            push_en  = 1'b1;
                            push_val = s_q.pb;
                            s_d.pb_v = 1'b0;
                            adv      = 1'b1;
                        end
                    end
                    OP_DUP: begin
                        push_en  = 1'b1;
                        push_val = top;
                        adv      = 1'b1;
                    end
                    OP_DROP: begin
                        pop_n = 2'd1;
                        adv   = 1'b1;
                    end
                    OP_SWAP: begin
                        swap_en = 1'b1;
                        adv     = 1'b1;
                    end
                    OP_ADD, OP_SUB, OP_AND, OP_XOR: begin
                        pop_n    = 2'd2;
                        push_en  = 1'b1;
                        push_val = alu_y;
                        adv      = 1'b1;
                    end
                    OP_LOAD: begin
                        mem_req       = 1'b1;
                        mem_addr      = top[AW-1:0];
                        dbusy         = 1'b1;
                        s_d.load_wait = 1'b1;
                    end
                    OP_STORE: begin
                        mem_req   = 1'b1;
                        mem_we    = 1'b1;
                        mem_addr  = top[AW-1:0];
                        mem_wdata = nos;
                        dbusy     = 1'b1;
                        pop_n     = 2'd2;
                        adv       = 1'b1;
                    end
                    OP_JMP: begin
                        pop_n = 2'd1;
                        jmp   = 1'b1;
                    end
                    OP_JZ: begin
                        pop_n = 2'd2;
                        if (nos == '0) begin
                            jmp = 1'b1;
                        end else begin
                            adv = 1'b1;
                        end
                    end
                    OP_HALT: begin
                        s_d.halted = 1'b1;
                    end
                    default: begin
                        adv = 1'b1;
                    end
                endcase
            end
        end

        // step to the next opcode slot
        if (adv) begin
            s_d.ir    = s_q.ir >> OPW;
            s_d.slots = s_q.slots - SW'(1);
            if (s_q.slots == SW'(1)) begin
                s_d.ir_v = 1'b0;
            end
        end

        // a jump flushes the current word and the prefetched word
        if (jmp) begin
            s_d.ir_v = 1'b0;
            s_d.pb_v = 1'b0;
        end

        // background fetch when the port is free and the buffer will be empty
        if (!s_d.halted && !dbusy && (jmp || (!s_q.pb_v && !s_q.f_inflight))) begin
            faddr          = jmp ? jtgt : s_q.ip;
            mem_req        = 1'b1;
            mem_addr       = faddr;
            s_d.ip         = faddr + AW'(1);
            s_d.f_inflight = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q    <= '0;
            s_q.ip <= RESET_IP;
        end else begin
            s_q <= s_d;
        end
    end

    assign halted  = s_q.halted;
    assign stk_err = s_q.err;
    assign depth   = cnt;
    assign tos     = (cnt == '0) ? '0 : top;

endmodule

// File: rtl/stk_core_chk.sv
module stk_core_chk #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          mem_req,
    input logic          mem_we,
    input logic          halted,
    input logic          stk_err,
    input logic [W-1:0]  tos,
    input logic [CW-1:0] depth
);

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (depth == '0) && !halted && !stk_err);

    p_halt_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        halted |-> !mem_req);

    p_halt_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(depth) && $stable(tos) && halted);

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        stk_err |=> stk_err);

    p_err_halts_r11: assert property (@(posedge clk) disable iff (rst)
        stk_err |-> halted);

    p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
        depth <= CW'(DEPTH));

    p_write_has_req_r12: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_req);

endmodule

bind stk_core stk_core_chk #(.W(W), .DEPTH(DEPTH), .CW(CW)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .mem_req (mem_req),
    .mem_we  (mem_we),
    .halted  (halted),
    .stk_err (stk_err),
    .tos     (tos),
    .depth   (depth)
);

// File: tb/stk_core_tb.sv
module stk_core_tb_top;
    import stk_core_pkg::*;

    localparam int CLK_P = 10;
    localparam int NV    = 9;

    function automatic logic [31:0] pk(input logic [4:0] a, b, c, d, e, f);
        return {2'b00, f, e, d, c, b, a};
    endfunction

    // six words per program, then expected tos and depth
    localparam logic [31:0] PROG [NV*6] = '{
        pk(OP_LIT, OP_LIT, OP_ADD, OP_HALT, OP_NOP, OP_NOP) | 32'hC000_0000, 32'd5, 32'd7, 0, 0, 0,
        pk(OP_LIT, OP_LIT, OP_SUB, OP_HALT, OP_NOP, OP_NOP), 32'd10, 32'd3, 0, 0, 0,
        pk(OP_LIT, OP_LIT, OP_XOR, OP_HALT, OP_NOP, OP_NOP), 32'hF0F0, 32'hFF00, 0, 0, 0,
        pk(OP_LIT, OP_LIT, OP_AND, OP_HALT, OP_NOP, OP_NOP), 32'hF0F0, 32'hFF00, 0, 0, 0,
        pk(OP_LIT, OP_LIT, OP_SWAP, OP_DROP, OP_HALT, OP_NOP), 32'd1, 32'd2, 0, 0, 0,
        pk(OP_LIT, OP_DUP, OP_ADD, OP_HALT, OP_NOP, OP_NOP), 32'd21, 0, 0, 0, 0,
        pk(OP_LIT, OP_NOP, OP_DUP, OP_DUP, OP_DUP, OP_DUP), 32'd9,
            pk(OP_HALT, OP_NOP, OP_NOP, OP_NOP, OP_NOP, OP_NOP), 0, 0, 0,
        pk(OP_LIT, OP_LIT, OP_JMP, OP_DUP, OP_DUP, OP_DUP), 32'd77, 32'd4,
            pk(OP_HALT, OP_NOP, OP_NOP, OP_NOP, OP_NOP, OP_NOP),
            pk(OP_DUP, OP_HALT, OP_NOP, OP_NOP, OP_NOP, OP_NOP), 0,
        pk(OP_LIT, OP_LIT, OP_LIT, OP_JZ, OP_DROP, OP_HALT), 32'd7, 32'd0, 32'd5,
            pk(OP_HALT, OP_NOP, OP_NOP, OP_NOP, OP_NOP, OP_NOP),
            pk(OP_DUP, OP_HALT, OP_NOP, OP_NOP, OP_NOP, OP_NOP)
    };
    localparam logic [31:0] EXP_TOS [NV] = '{32'd12, 32'd7, 32'h0FF0, 32'hF000, 32'd2,
                                             32'd42, 32'd9, 32'd77, 32'd7};
    localparam int EXP_DEP [NV] = '{1, 1, 1, 1, 1, 1, 1, 2, 2};
    localparam string VTAG [NV] = '{"R2 R4 ADD", "R4 R5 SUB", "R5 XOR", "R5 AND",
                                    "R6 SWAP/DROP", "R6 DUP", "R3 NOP", "R8 JMP", "R9 JZ taken"};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mem_req, mem_we, halted, stk_err;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata, tos;
    logic [4:0]  depth;

    logic        ld_en = 1'b0;
    logic [5:0]  ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic [31:0] mem [64];

    int nchk = 0;
    int nfail = 0;
    int bad_we = 0;

    always #(CLK_P/2) clk = ~clk;

    stk_core dut_i (
        .clk       (clk),
        .rst       (rst),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .halted    (halted),
        .stk_err   (stk_err),
        .tos       (tos),
        .depth     (depth)
    );

    always @(posedge clk) begin
        if (ld_en) begin
            mem[ld_addr] <= ld_data;
        end else if (mem_req) begin
            if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[5:0]];
        end
    end

    always @(negedge clk) if (!rst && mem_we && !mem_req) bad_we++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic put(input int a, input logic [31:0] d);
        ld_en   = 1'b1;
        ld_addr = 6'(a);
        ld_data = d;
        @(negedge clk);
        ld_en   = 1'b0;
    endtask

    task automatic clear_mem();
        rst = 1'b1;
        for (int i = 0; i < 64; i++) put(i, 32'd0);
    endtask

    task automatic go(input string tag);
        rst = 1'b0;
        for (int c = 0; c < 400 && !halted; c++) @(negedge clk);
        chk({tag, " halts"}, {31'd0, halted}, 32'd1);
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        nchk++;
        nfail++;
        $display("FAIL watchdog: run did not end");
        summary();
    end

    initial begin
        @(negedge clk);
        clear_mem();
        // R1: reset state and first fetch address
        chk("R1 halted", {31'd0, halted}, 32'd0);
        chk("R1 stk_err", {31'd0, stk_err}, 32'd0);
        chk("R1 depth", 32'(depth), 32'd0);
        chk("R1 tos", tos, 32'd0);
        chk("R1 first fetch", {15'd0, mem_req, mem_addr}, {15'd0, 1'b1, 16'd0});

        // table of programs
        for (int v = 0; v < NV; v++) begin
            clear_mem();
            for (int w = 0; w < 6; w++) put(w, PROG[v*6 + w]);
            go(VTAG[v]);
            chk({VTAG[v], " tos"}, tos, EXP_TOS[v]);
            chk({VTAG[v], " depth"}, 32'(depth), 32'(EXP_DEP[v]));
            chk({VTAG[v], " no error"}, {31'd0, stk_err}, 32'd0);
        end

        // R10: after HALT no request and frozen stack
        begin
            int reqs = 0;
            logic [31:0] t0;
            t0 = tos;
            for (int c = 0; c < 10; c++) begin
                @(negedge clk);
                if (mem_req) reqs++;
            end
            chk("R10 no requests", 32'(reqs), 32'd0);
            chk("R10 tos frozen", tos, t0);
        end

        // R9: JZ not taken falls through to DROP, HALT
        clear_mem();
        put(0, pk(OP_LIT, OP_LIT, OP_LIT, OP_JZ, OP_DROP, OP_HALT));
        put(1, 32'd7); put(2, 32'd1); put(3, 32'd5);
        put(4, pk(OP_HALT, OP_NOP, OP_NOP, OP_NOP, OP_NOP, OP_NOP));
        put(5, pk(OP_DUP, OP_HALT, OP_NOP, OP_NOP, OP_NOP, OP_NOP));
        go("R9 JZ not taken");
        chk("R9 not taken depth", 32'(depth), 32'd0);

        // R7 and R12: STORE then LOAD through the memory port
        clear_mem();
        put(0, pk(OP_LIT, OP_LIT, OP_STORE, OP_LIT, OP_LOAD, OP_HALT));
        put(1, 32'h0000_1234); put(2, 32'd40); put(3, 32'd40);
        go("R7 store/load");
        chk("R7 loaded tos", tos, 32'h0000_1234);
        chk("R7 depth", 32'(depth), 32'd1);
        chk("R12 stored word", mem[40], 32'h0000_1234);
        chk("R12 write without request", 32'(bad_we), 32'd0);

        // R11: underflow on SWAP leaves stack as is
        clear_mem();
        put(0, pk(OP_LIT, OP_SWAP, OP_HALT, OP_NOP, OP_NOP, OP_NOP));
        put(1, 32'd4);
        go("R11 underflow");
        chk("R11 underflow err", {31'd0, stk_err}, 32'd1);
        chk("R11 underflow depth", 32'(depth), 32'd1);
        chk("R11 underflow tos", tos, 32'd4);

        // R11: overflow on the seventeenth push
        clear_mem();
        put(0, pk(OP_LIT, OP_DUP, OP_DUP, OP_DUP, OP_DUP, OP_DUP));
        put(1, 32'd5);
        put(2, pk(OP_DUP, OP_DUP, OP_DUP, OP_DUP, OP_DUP, OP_DUP));
        put(3, pk(OP_DUP, OP_DUP, OP_DUP, OP_DUP, OP_DUP, OP_DUP));
        go("R11 overflow");
        chk("R11 overflow err", {31'd0, stk_err}, 32'd1);
        chk("R11 overflow depth", 32'(depth), 32'd16);
        chk("R11 overflow tos", tos, 32'd5);
        repeat (5) @(negedge clk);
        chk("R11 err sticky", {31'd0, stk_err}, 32'd1);

        // R1: reset clears the error
        clear_mem();
        chk("R1 err cleared", {31'd0, stk_err}, 32'd0);
        chk("R1 halted cleared", {31'd0, halted}, 32'd0);

        summary();
    end

endmodule